// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block time-stamps input events against a free-running count value that it receives from elsewhere. There are four channels. Each one watches a chosen source: its own pin, the pin of its pair partner, or a shared internal trigger. The source passes through a noise filter of selectable length, then through an edge detector with a selectable edge mode, then through an event divider. When a qualified event reaches the divider, the channel copies the count value into its capture register and raises a sticky flag.

Software clears each flag on its own. A single interrupt line is active while any flag is set on a channel whose interrupt enable is on. The pins are asynchronous and go through a two-flop synchronizer first. The internal trigger is taken as already synchronous to the clock.

Top module: `edge_stamp_capture`

## Requirements
- R1: After reset every capture register reads 0, every flag reads 0 and the interrupt line is low.
- R2: On a qualified pin event, the capture register loads the count value present two cycles plus N cycles after the pin change is first sampled, where N is the filter length. For example, with N=1 a pin set at the count value C captures C+3.
- R3: The two polarity bits (P, NP) select the edge mode: P=0 gives rising only, P=1 with NP=0 gives falling only, P=1 with NP=1 gives both edges, and P=0 with NP=1 acts as rising only.
- R4: The source field selects the input: 0 selects the channel's own pin, 1 selects the partner pin (channel index XOR 1), and 2 or 3 selects the internal trigger. The trigger skips the synchronizer, so a trigger change made at count C captures C+N.
- R5: The divider field values 0, 1, 2 and 3 capture on every 1st, 2nd, 4th and 8th qualified edge. The edge counter restarts from zero while the channel is disabled.
- R6: The filter field values 0, 1, 2 and 3 require 1, 2, 4 and 8 consecutive samples of a new level before the filtered level changes. Shorter pulses are dropped.
- R7: While a channel's enable is 0, its capture register and flag do not change on input edges.
- R8: A capture sets the channel flag. A clear pulse resets the flag on the next clock edge. If a capture and a clear happen in the same cycle, the capture wins.
- R9: The interrupt line is high exactly when some channel has both its flag and its interrupt enable set.
- R10: A capture register keeps its value until the next capture on that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_val | input | CNT_W | Running count value to be stamped |
| cap_pin | input | NUM_CH | Asynchronous channel pins |
| trig_in | input | 1 | Shared internal trigger, synchronous |
| ch_en | input | NUM_CH | Per-channel capture enable |
| pol_p | input | NUM_CH | Polarity bit P per channel |
| pol_np | input | NUM_CH | Polarity bit NP per channel |
| src_sel | input | 2*NUM_CH | Source select, 2 bits per channel |
| psc_sel | input | 2*NUM_CH | Event divider select, 2 bits per channel |
| flt_sel | input | 2*NUM_CH | Filter length select, 2 bits per channel |
| irq_en | input | NUM_CH | Per-channel interrupt enable |
| flag_clr | input | NUM_CH | Per-channel flag clear pulse |
| cap_val | output | NUM_CH*CNT_W | Capture registers, channel 0 in the low bits |
| cap_flag | output | NUM_CH | Capture flags |
| irq | output | 1 | Interrupt request |

## Verification
Directed cases drive single clean edges into each channel in each edge mode and compare the stamped count with the expected latency. This separates the path through the pin synchronizer from the trigger path, and filter length 1 from filter length 4. Further directed cases cover a pulse shorter than the filter, pin activity on a channel that has selected its partner, a divide-by-two sequence in which only the second edge stamps, and trigger edges on a disabled channel. A long random phase then toggles pins, the trigger and clear pulses, and reconfigures channels on the fly, comparing every output on every cycle against a bench model. That phase reaches capture/clear collisions, the reserved polarity code and mid-run changes to the divider and filter settings.

// File: rtl/capt_pkg.sv
// Shared widths, encodings and helpers for the edge timestamp capture unit.
// Assumes every 2-bit config field selects a power of two from 1 to 8.
package capt_pkg;
    localparam int CFG_W = 2;
    localparam int RUN_W = (1 << CFG_W);

    typedef enum logic [CFG_W-1:0] {
        SRC_OWN   = 2'd0,
        SRC_PAIR  = 2'd1,
        SRC_TRIG  = 2'd2,
        SRC_TRIGB = 2'd3
    } src_sel_e;

    // Power-of-two length selected by a config field: 1, 2, 4 or 8.
    function automatic logic [RUN_W-1:0] span(input logic [CFG_W-1:0] sel);
        span = RUN_W'(1) << sel;
    endfunction

    // Picks the edge that counts as an event for the given polarity bits.
    function automatic logic edge_pick(input logic p, input logic np,
                                       input logic rise, input logic fall);
        if (!p)
            edge_pick = rise;
        else if (np)
            edge_pick = rise | fall;
        else
            edge_pick = fall;
    endfunction
endpackage

// File: rtl/capt_sync.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no cross-bit coherence is provided.
module capt_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two register stages bring the pins into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/capt_filter.sv
// Level filter: the output takes a new level only after the input has shown
// that level for span(flt_sel) consecutive samples.
// Assumes din is synchronous. The output resets low.
module capt_filter
    import capt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [CFG_W-1:0] flt_sel,
    output logic             dout
);
    logic [RUN_W-1:0] run_q;
    logic             level_q;
    logic [RUN_W-1:0] need;

    assign need = span(flt_sel);

    // Count samples that differ from the held level; adopt the level once enough are seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            run_q   <= '0;
        end else if (din == level_q) begin
            run_q <= '0;
        end else if ((run_q + RUN_W'(1)) >= need) begin
            level_q <= din;
            run_q   <= '0;
        end else begin
            run_q <= run_q + RUN_W'(1);
        end
    end

    assign dout = level_q;

    // R6: the filtered level only moves to a value the input held on the previous sample.
    p_level_from_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> ($past(din) == level_q));

    // R6: with the shortest filter, a differing sample is adopted at once.
    p_short_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_sel == '0 && din != level_q) |=> (level_q == $past(din)));
endmodule

// File: rtl/capt_channel.sv
// One capture channel: edge selection on a filtered level, event divider,
// capture register and sticky flag.
// Assumes the level is already synchronous and filtered.
module capt_channel
    import capt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    input  logic             enable,
    input  logic             pol_p,
    input  logic             pol_np,
    input  logic [CFG_W-1:0] psc_sel,
    input  logic [CNT_W-1:0] count_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag
);
    logic             prev_q;
    logic             rise;
    logic             fall;
    logic             hit;
    logic             fire;
    logic [RUN_W-1:0] ev_q;
    logic [RUN_W-1:0] div;
    logic [CNT_W-1:0] cap_q;
    logic             flag_q;

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;
    assign hit  = edge_pick(pol_p, pol_np, rise, fall);
    assign div  = span(psc_sel);
    assign fire = enable & hit & ((ev_q + RUN_W'(1)) >= div);

    // Remember the previous filtered level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // Count qualified edges between captures; hold at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) ev_q <= '0;
        else if (fire)         ev_q <= '0;
        else if (hit)          ev_q <= ev_q + RUN_W'(1);
    end

    // Latch the count value on a capture.
    always_ff @(posedge clk) begin
        if (!rst_n)    cap_q <= '0;
        else if (fire) cap_q <= count_val;
    end

    // Sticky flag: a capture sets it and wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (fire)     flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign cap_val  = cap_q;
    assign cap_flag = flag_q;

    // R2: a capture stores the count value seen in the capture cycle.
    p_load_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cap_q == $past(count_val)));

    // R10: without a capture the register keeps its value.
    p_hold_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(cap_q));

    // R8: a capture always leaves the flag set, even with a clear in the same cycle.
    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cap_flag);

    // R8: a clear without a capture drops the flag.
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !fire) |=> !cap_flag);

    // R3: a capture only happens when the filtered level has just changed.
    p_edge_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (level != prev_q));

    // R7: a disabled channel leaves its flag where it was unless cleared.
    p_disabled_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !flag_clr) |=> $stable(cap_flag));

    // R5: an enabled edge that does not capture advances the divider.
    p_divider_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && hit && !fire) |=> (ev_q == $past(ev_q) + RUN_W'(1)));
endmodule

// File: rtl/edge_stamp_capture.sv
// Top of the edge timestamp capture unit. It synchronizes the pins, selects
// each channel's source, filters it and runs one capture channel per input.
// Assumes trig_in is synchronous to clk, and that the partner of channel i is
// channel i^1 when that channel exists (otherwise the channel's own pin).
module edge_stamp_capture
    import capt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        count_val,
    input  logic [NUM_CH-1:0]       cap_pin,
    input  logic                    trig_in,
    input  logic [NUM_CH-1:0]       ch_en,
    input  logic [NUM_CH-1:0]       pol_p,
    input  logic [NUM_CH-1:0]       pol_np,
    input  logic [NUM_CH*CFG_W-1:0] src_sel,
    input  logic [NUM_CH*CFG_W-1:0] psc_sel,
    input  logic [NUM_CH*CFG_W-1:0] flt_sel,
    input  logic [NUM_CH-1:0]       irq_en,
    input  logic [NUM_CH-1:0]       flag_clr,
    output logic [NUM_CH*CNT_W-1:0] cap_val,
    output logic [NUM_CH-1:0]       cap_flag,
    output logic                    irq
);
    logic [NUM_CH-1:0] pin_s;
    logic [NUM_CH-1:0] chosen;
    logic [NUM_CH-1:0] filt;

    capt_sync #(.W(NUM_CH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cap_pin),
        .dout  (pin_s)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int PAIR = ((i ^ 1) < NUM_CH) ? (i ^ 1) : i;
        src_sel_e src;

        assign src = src_sel_e'(src_sel[i*CFG_W +: CFG_W]);

        // Route the selected source into this channel's filter.
        always_comb begin
            case (src)
                SRC_OWN:  chosen[i] = pin_s[i];
                SRC_PAIR: chosen[i] = pin_s[PAIR];
                default:  chosen[i] = trig_in;
            endcase
        end

        capt_filter u_filter (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (chosen[i]),
            .flt_sel (flt_sel[i*CFG_W +: CFG_W]),
            .dout    (filt[i])
        );

        capt_channel #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .level     (filt[i]),
            .enable    (ch_en[i]),
            .pol_p     (pol_p[i]),
            .pol_np    (pol_np[i]),
            .psc_sel   (psc_sel[i*CFG_W +: CFG_W]),
            .count_val (count_val),
            .flag_clr  (flag_clr[i]),
            .cap_val   (cap_val[i*CNT_W +: CNT_W]),
            .cap_flag  (cap_flag[i])
        );
    end

    assign irq = |(cap_flag & irq_en);

    // R9: the interrupt is never raised without some flag being set.
    p_irq_has_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cap_flag != '0));

    // R1: in the cycle after reset, all flags are clear.
    p_reset_clean_r1: assert property (@(posedge clk)
        !rst_n |=> (cap_flag == '0));
endmodule

// File: tb/test_edge_stamp_capture.sv
module test_edge_stamp_capture;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int CW  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CW-1:0]   count_val = '0;
    logic [NCH-1:0]  cap_pin = '0;
    logic            trig_in = 1'b0;
    logic [NCH-1:0]  ch_en = '0;
    logic [NCH-1:0]  pol_p = '0;
    logic [NCH-1:0]  pol_np = '0;
    logic [2*NCH-1:0] src_sel = '0;
    logic [2*NCH-1:0] psc_sel = '0;
    logic [2*NCH-1:0] flt_sel = '0;
    logic [NCH-1:0]  irq_en = '0;
    logic [NCH-1:0]  flag_clr = '0;
    logic [NCH*CW-1:0] cap_val;
    logic [NCH-1:0]  cap_flag;
    logic            irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    edge_stamp_capture #(.NUM_CH(NCH), .CNT_W(CW)) i_edge_stamp_capture (
        .clk(clk), .rst_n(rst_n), .count_val(count_val), .cap_pin(cap_pin),
        .trig_in(trig_in), .ch_en(ch_en), .pol_p(pol_p), .pol_np(pol_np),
        .src_sel(src_sel), .psc_sel(psc_sel), .flt_sel(flt_sel),
        .irq_en(irq_en), .flag_clr(flag_clr), .cap_val(cap_val),
        .cap_flag(cap_flag), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench reference model, written from the requirements.
    logic [NCH-1:0] m_s1, m_s2, m_f, m_prev, m_flag;
    int             m_fc [NCH];
    int             m_pc [NCH];
    logic [CW-1:0]  m_cap [NCH];

    function automatic logic m_src(input int i, input logic [NCH-1:0] s2, input logic t);
        int sel = int'(src_sel[2*i +: 2]);
        if (sel == 0) return s2[i];
        if (sel == 1) return s2[i ^ 1];
        return t;
    endfunction

    function automatic logic m_hit(input logic p, input logic np, input logic r, input logic f);
        if (!p) return r;
        return np ? (r | f) : f;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_f <= '0; m_prev <= '0; m_flag <= '0;
            for (int i = 0; i < NCH; i++) begin
                m_fc[i] <= 0; m_pc[i] <= 0; m_cap[i] <= '0;
            end
        end else begin
            m_s1 <= cap_pin;
            m_s2 <= m_s1;
            m_prev <= m_f;
            for (int i = 0; i < NCH; i++) begin
                logic din, h, cap;
                int need, dv;
                din  = m_src(i, m_s2, trig_in);
                need = 1 << flt_sel[2*i +: 2];
                dv   = 1 << psc_sel[2*i +: 2];
                if (din == m_f[i]) m_fc[i] <= 0;
                else if (m_fc[i] + 1 >= need) begin m_f[i] <= din; m_fc[i] <= 0; end
                else m_fc[i] <= m_fc[i] + 1;
                h = m_hit(pol_p[i], pol_np[i], m_f[i] & ~m_prev[i], ~m_f[i] & m_prev[i]);
                cap = ch_en[i] && h && (m_pc[i] + 1 >= dv);
                if (!ch_en[i] || cap) m_pc[i] <= 0;
                else if (h) m_pc[i] <= m_pc[i] + 1;
                if (cap) begin m_cap[i] <= count_val; m_flag[i] <= 1'b1; end
                else if (flag_clr[i]) m_flag[i] <= 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance to the next falling edge and step the count value.
    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            count_val = count_val + 1'b1;
        end
    endtask

    function automatic logic [CW-1:0] capv(input int i);
        return cap_val[i*CW +: CW];
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] rec, old;
        void'($urandom(32'd2718));
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 cap_val", cap_val[31:0], 32'h0);
        chk("R1 cap_flag", cap_flag, 0);
        chk("R1 irq", irq, 0);

        // R2 rising capture, own pin, filter length 1
        ch_en[0] = 1'b1;
        tick(2);
        cap_pin[0] = 1'b1; rec = count_val;
        tick(6);
        chk("R2 rising stamp ch0", capv(0), rec + 3);
        chk("R8 flag set ch0", cap_flag[0], 1);
        chk("R9 irq masked", irq, 0);
        irq_en[0] = 1'b1;
        tick(1);
        chk("R9 irq enabled", irq, 1);
        flag_clr[0] = 1'b1;
        tick(1);
        flag_clr[0] = 1'b0;
        chk("R8 flag cleared ch0", cap_flag[0], 0);
        chk("R9 irq drops", irq, 0);
        old = capv(0);
        cap_pin[0] = 1'b0;
        tick(6);
        chk("R3 falling ignored in rising mode", cap_flag[0], 0);
        chk("R10 value held ch0", capv(0), old);

        // R3 falling-only mode on ch1
        ch_en[1] = 1'b1; pol_p[1] = 1'b1;
        tick(2);
        cap_pin[1] = 1'b1;
        tick(6);
        chk("R3 rise ignored in falling mode", cap_flag[1], 0);
        cap_pin[1] = 1'b0; rec = count_val;
        tick(6);
        chk("R3 falling stamp ch1", capv(1), rec + 3);

        // R6 both edges with filter length 4 on ch2
        ch_en[2] = 1'b1; pol_p[2] = 1'b1; pol_np[2] = 1'b1; flt_sel[5:4] = 2'd2;
        tick(2);
        cap_pin[2] = 1'b1; rec = count_val;
        tick(10);
        chk("R6 filtered stamp ch2", capv(2), rec + 6);
        old = capv(2);
        flag_clr[2] = 1'b1; tick(1); flag_clr[2] = 1'b0;
        cap_pin[2] = 1'b0; tick(2); cap_pin[2] = 1'b1;
        tick(12);
        chk("R6 short pulse dropped value", capv(2), old);
        chk("R6 short pulse dropped flag", cap_flag[2], 0);

        // R4 partner source on ch3 (takes pin 2)
        src_sel[7:6] = 2'd1; pol_p[3] = 1'b1;
        tick(8);
        ch_en[3] = 1'b1;
        tick(2);
        cap_pin[3] = 1'b1; tick(6); cap_pin[3] = 1'b0; tick(6);
        chk("R4 own pin ignored when partner selected", cap_flag[3], 0);
        cap_pin[2] = 1'b0; rec = count_val;
        tick(8);
        chk("R4 partner stamp ch3", capv(3), rec + 3);
        chk("R3 both-edges fall stamp ch2", capv(2), rec + 6);

        // R4 internal trigger on ch0, no synchronizer
        ch_en[0] = 1'b0; src_sel[1:0] = 2'd2;
        tick(4);
        ch_en[0] = 1'b1;
        tick(2);
        trig_in = 1'b1; rec = count_val;
        tick(4);
        chk("R4 trigger stamp ch0", capv(0), rec + 1);

        // R5 divide by two on ch1 (falling mode)
        psc_sel[3:2] = 2'd1; flag_clr[1] = 1'b1; tick(1); flag_clr[1] = 1'b0;
        old = capv(1);
        cap_pin[1] = 1'b1; tick(4); cap_pin[1] = 1'b0;
        tick(6);
        chk("R5 first edge skipped value", capv(1), old);
        chk("R5 first edge skipped flag", cap_flag[1], 0);
        cap_pin[1] = 1'b1; tick(4); cap_pin[1] = 1'b0; rec = count_val;
        tick(6);
        chk("R5 second edge stamp", capv(1), rec + 3);

        // R7 disabled channel ignores trigger edges
        ch_en[0] = 1'b0; flag_clr[0] = 1'b1; tick(1); flag_clr[0] = 1'b0;
        old = capv(0);
        trig_in = 1'b0; tick(4); trig_in = 1'b1; tick(4);
        chk("R7 disabled value held", capv(0), old);
        chk("R7 disabled flag held", cap_flag[0], 0);

        // Random phase compared against the model (R2..R10)
        for (int c = 0; c < 6000; c++) begin
            for (int i = 0; i < NCH; i++) begin
                chk("R2-model cap", capv(i), m_cap[i]);
            end
            chk("R8-model flags", cap_flag, m_flag);
            chk("R9-model irq", irq, |(m_flag & irq_en));
            if ($urandom_range(0, 5) == 0) cap_pin[$urandom_range(0, NCH-1)] ^= 1'b1;
            if ($urandom_range(0, 7) == 0) trig_in = ~trig_in;
            flag_clr = ($urandom_range(0, 3) == 0) ? NCH'($urandom) : '0;
            if ($urandom_range(0, 63) == 0) begin
                ch_en = NCH'($urandom); pol_p = NCH'($urandom); pol_np = NCH'($urandom);
                src_sel = 8'($urandom); psc_sel = 8'($urandom); flt_sel = 8'($urandom);
                irq_en = NCH'($urandom);
            end
            tick(1);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule